// File: doc/BRIEF.md
# Register Write-Pending Hazard Scoreboard

This block tracks, for every architectural register, whether a write to it is still outstanding. Issue logic tells it when an instruction that will write a register has been issued (set requests). Writeback logic tells it when a register has actually been written (clear requests). There can be several of each per cycle. Every request names its register either as a one-hot mask or as a binary register number with a valid bit, chosen per request by a format bit.

The block presents two views of the pending state. The first is the registered vector. The second is a bypass view that already includes this cycle's clears and the delayed set. A set request waits in a one-cycle stage before it reaches either view. As a result, an instruction that reads and writes the same register does not see its own pending write.

Read operands are checked against the registered vector. Destinations are checked against the bypass view, so that a write-after-write hazard is seen one cycle earlier. Each checked operand or destination stops checking once its unit reports busy without a hazard. The merged read and write hazard flags let issue logic hold an instruction.

Top module: `pend_scoreboard`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the pending vector, the delayed set stage and every operand's settled state are cleared. After that edge `pend_q` and `pend_byp` read all zero.
- R2: The set masks of all set ports are OR-merged. A set requested in cycle t appears in `pend_byp` during cycle t+1 and in `pend_q` from cycle t+2.
- R3: The clear masks of all clear ports are OR-merged. A cleared bit reads 0 in `pend_byp` in the same cycle and in `pend_q` after the next edge, unless R4 applies.
- R4: If the delayed set and a clear hit the same bit in the same cycle, the bit ends up set.
- R5: A request with format bit 0 uses its mask as given. With format bit 1 it uses the one-hot value 1 shifted left by its number. A request whose valid bit is 0 has no effect, whatever its mask or number.
- R6: `rd_hz[i]` is high when read check i is valid, has not settled, and its register mask overlaps `pend_q`. The result is combinational in the same cycle.
- R7: `wr_hz[i]` is high when destination check i is valid, has not settled, and its register mask overlaps `pend_byp`. A destination therefore hazards one cycle after the set request, while `pend_q` does not yet show it.
- R8: A read check of register r in the same cycle as a set request for r shows no hazard from that set.
- R9: If a check is valid with its busy input high and its hazard low at an edge, it reports no hazard for as long as its valid bit stays high. Other checks on the same register are unaffected.
- R10: `raw_any` is the OR of all `rd_hz` bits, and `waw_any` is the OR of all `wr_hz` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| set_vld | input | NSET | Set request valid, one per set port |
| set_fmt | input | NSET | Set format: 0 mask, 1 number |
| set_mask | input | NSET*NREG | Set register masks, port p at bits p*NREG |
| set_num | input | NSET*IW | Set register numbers, port p at bits p*IW |
| clr_vld | input | NCLR | Clear request valid |
| clr_fmt | input | NCLR | Clear format: 0 mask, 1 number |
| clr_mask | input | NCLR*NREG | Clear register masks |
| clr_num | input | NCLR*IW | Clear register numbers |
| rd_vld | input | NRD | Read check valid |
| rd_fmt | input | NRD | Read check format |
| rd_mask | input | NRD*NREG | Read check masks |
| rd_num | input | NRD*IW | Read check numbers |
| rd_busy | input | NRD | Requesting unit busy, per read check |
| wr_vld | input | NWR | Destination check valid |
| wr_fmt | input | NWR | Destination check format |
| wr_mask | input | NWR*NREG | Destination check masks |
| wr_num | input | NWR*IW | Destination check numbers |
| wr_busy | input | NWR | Requesting unit busy, per destination check |
| pend_q | output | NREG | Registered pending vector |
| pend_byp | output | NREG | Bypass view with this cycle's changes |
| rd_hz | output | NRD | Read-after-write hazard per read check |
| wr_hz | output | NWR | Write-after-write hazard per destination check |
| raw_any | output | 1 | OR of all read hazards |
| waw_any | output | 1 | OR of all destination hazards |

## Verification
On every cycle the assertions check the following:
- reset clearing;
- the visibility of a merged set one cycle after its request;
- clearing of bits that no delayed set protects;
- set-over-clear priority;
- that no hazard is raised from an empty view or from an invalid check;
- that a settled check stays quiet.

Other behaviours can only be shown by the bench's scenarios:
- the two request formats and the dropping of invalid requests;
- the absence of self-hazard in the issue cycle;
- the one-cycle gap between a destination hazard on the bypass view and a read hazard on the registered vector;
- the fact that one settled check leaves another check on the same register holding.

// File: rtl/pend_pkg.sv
`timescale 1ns/1ps
// Package pend_pkg
// Shared encodings for the pending-write scoreboard.
// Assumes: a request's format bit selects how its register field is read.
package pend_pkg;

    // How a request names its register
    typedef enum logic {
        REQ_MASK = 1'b0,   // one-hot (or multi-hot) mask used directly
        REQ_NUM  = 1'b1    // binary register number, decoded to one-hot
    } req_fmt_e;

endpackage

// File: rtl/pend_decode.sv
`timescale 1ns/1ps
// Module pend_decode
// Turns one request (valid, format, mask, number) into a register mask.
// Assumes: with a number, 1 is shifted left by it; a number past the
// top register decodes to no bit. An invalid request decodes to zero.
module pend_decode #(
    parameter int NREG = 32,
    parameter int IW   = 5
) (
    input  logic            vld,
    input  logic            fmt,
    input  logic [NREG-1:0] mask,
    input  logic [IW-1:0]   num,
    output logic [NREG-1:0] onehot
);
    import pend_pkg::*;

    localparam logic [NREG-1:0] ONE = NREG'(1);

    // select mask or shifted number, gated by valid
    always_comb begin
        onehot = '0;
        if (vld) begin
            if (req_fmt_e'(fmt) == REQ_NUM) begin
                onehot = ONE << num;
            end else begin
                onehot = mask;
            end
        end
    end

endmodule

// File: rtl/pend_req_merge.sv
`timescale 1ns/1ps
// Module pend_req_merge
// Decodes NPORT requests and OR-reduces them into one register mask.
// Assumes: no port has priority over another; every asserted bit survives.
module pend_req_merge #(
    parameter int NREG  = 32,
    parameter int NPORT = 2,
    parameter int IW    = 5
) (
    input  logic [NPORT-1:0]      vld,
    input  logic [NPORT-1:0]      fmt,
    input  logic [NPORT*NREG-1:0] mask,
    input  logic [NPORT*IW-1:0]   num,
    output logic [NREG-1:0]       merged
);
    logic [NREG-1:0] dec [NPORT];

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        pend_decode #(.NREG(NREG), .IW(IW)) u_dec (
            .vld    (vld[p]),
            .fmt    (fmt[p]),
            .mask   (mask[p*NREG +: NREG]),
            .num    (num[p*IW +: IW]),
            .onehot (dec[p])
        );
    end

    // OR every decoded port into the merged mask
    always_comb begin
        merged = '0;
        for (int p = 0; p < NPORT; p++) begin
            merged = merged | dec[p];
        end
    end

endmodule

// File: rtl/pend_vec.sv
`timescale 1ns/1ps
// Module pend_vec
// Holds the pending-write vector. The merged set mask waits one cycle in
// set_dly before it reaches the vector. Clears act in the cycle they
// arrive. Where the delayed set and a clear meet on one bit, the set wins.
// Assumes: synchronous active-low reset empties both stages.
module pend_vec #(
    parameter int NREG = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREG-1:0] set_req,
    input  logic [NREG-1:0] clr_req,
    output logic [NREG-1:0] set_dly,
    output logic [NREG-1:0] vec_q,
    output logic [NREG-1:0] vec_byp
);
    // delay stage for issue-time set requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_dly <= '0;
        end else begin
            set_dly <= set_req;
        end
    end

    // next-state view: clears applied, then the delayed set on top
    always_comb begin
        vec_byp = (vec_q & ~clr_req) | set_dly;
    end

    // registered pending vector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else begin
            vec_q <= vec_byp;
        end
    end

endmodule

// File: rtl/pend_check.sv
`timescale 1ns/1ps
// Module pend_check
// Compares NCHK operand or destination masks against one view of the
// pending vector. A check that saw its unit busy with no hazard settles
// and stays quiet until its valid bit drops.
// Assumes: the busy input is registered in the unit, so the settle
// path feeds back only through settled_q.
module pend_check #(
    parameter int NREG = 32,
    parameter int NCHK = 2,
    parameter int IW   = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NREG-1:0]      view,
    input  logic [NCHK-1:0]      vld,
    input  logic [NCHK-1:0]      fmt,
    input  logic [NCHK*NREG-1:0] mask,
    input  logic [NCHK*IW-1:0]   num,
    input  logic [NCHK-1:0]      busy,
    output logic [NCHK-1:0]      hz,
    output logic                 any
);
    for (genvar i = 0; i < NCHK; i++) begin : g_chk
        logic [NREG-1:0] want;
        logic            settled_q;
        logic            hit;

        pend_decode #(.NREG(NREG), .IW(IW)) u_dec (
            .vld    (vld[i]),
            .fmt    (fmt[i]),
            .mask   (mask[i*NREG +: NREG]),
            .num    (num[i*IW +: IW]),
            .onehot (want)
        );

        // hazard while still checking and the view overlaps the request
        always_comb begin
            hit = vld[i] & ~settled_q & (|(view & want));
        end

        // settle once the unit is busy without a hazard; release on invalid
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                settled_q <= 1'b0;
            end else begin
                settled_q <= vld[i] & (settled_q | (busy[i] & ~hit));
            end
        end

        assign hz[i] = hit;
    end

    // merged flag across all checks
    always_comb begin
        any = |hz;
    end

endmodule

// File: rtl/pend_scoreboard.sv
`timescale 1ns/1ps
// Module pend_scoreboard
// Pending-write scoreboard: merges set and clear requests, keeps the
// pending vector, and raises read and write-after-write hazards.
// Assumes: read checks use the registered vector, destination checks
// the bypass view; the issue control acts on raw_any and waw_any.
module pend_scoreboard #(
    parameter int NREG = 32,
    parameter int NSET = 2,
    parameter int NCLR = 2,
    parameter int NRD  = 3,
    parameter int NWR  = 2,
    localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NSET-1:0]      set_vld,
    input  logic [NSET-1:0]      set_fmt,
    input  logic [NSET*NREG-1:0] set_mask,
    input  logic [NSET*IW-1:0]   set_num,
    input  logic [NCLR-1:0]      clr_vld,
    input  logic [NCLR-1:0]      clr_fmt,
    input  logic [NCLR*NREG-1:0] clr_mask,
    input  logic [NCLR*IW-1:0]   clr_num,
    input  logic [NRD-1:0]       rd_vld,
    input  logic [NRD-1:0]       rd_fmt,
    input  logic [NRD*NREG-1:0]  rd_mask,
    input  logic [NRD*IW-1:0]    rd_num,
    input  logic [NRD-1:0]       rd_busy,
    input  logic [NWR-1:0]       wr_vld,
    input  logic [NWR-1:0]       wr_fmt,
    input  logic [NWR*NREG-1:0]  wr_mask,
    input  logic [NWR*IW-1:0]    wr_num,
    input  logic [NWR-1:0]       wr_busy,
    output logic [NREG-1:0]      pend_q,
    output logic [NREG-1:0]      pend_byp,
    output logic [NRD-1:0]       rd_hz,
    output logic [NWR-1:0]       wr_hz,
    output logic                 raw_any,
    output logic                 waw_any
);
    logic [NREG-1:0] set_m;
    logic [NREG-1:0] clr_m;
    logic [NREG-1:0] set_dly;

    pend_req_merge #(.NREG(NREG), .NPORT(NSET), .IW(IW)) u_set_merge (
        .vld    (set_vld),
        .fmt    (set_fmt),
        .mask   (set_mask),
        .num    (set_num),
        .merged (set_m)
    );

    pend_req_merge #(.NREG(NREG), .NPORT(NCLR), .IW(IW)) u_clr_merge (
        .vld    (clr_vld),
        .fmt    (clr_fmt),
        .mask   (clr_mask),
        .num    (clr_num),
        .merged (clr_m)
    );

    pend_vec #(.NREG(NREG)) u_vec (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (set_m),
        .clr_req (clr_m),
        .set_dly (set_dly),
        .vec_q   (pend_q),
        .vec_byp (pend_byp)
    );

    pend_check #(.NREG(NREG), .NCHK(NRD), .IW(IW)) u_rd_chk (
        .clk   (clk),
        .rst_n (rst_n),
        .view  (pend_q),
        .vld   (rd_vld),
        .fmt   (rd_fmt),
        .mask  (rd_mask),
        .num   (rd_num),
        .busy  (rd_busy),
        .hz    (rd_hz),
        .any   (raw_any)
    );

    pend_check #(.NREG(NREG), .NCHK(NWR), .IW(IW)) u_wr_chk (
        .clk   (clk),
        .rst_n (rst_n),
        .view  (pend_byp),
        .vld   (wr_vld),
        .fmt   (wr_fmt),
        .mask  (wr_mask),
        .num   (wr_num),
        .busy  (wr_busy),
        .hz    (wr_hz),
        .any   (waw_any)
    );

endmodule

// File: rtl/pend_scoreboard_chk.sv
`timescale 1ns/1ps
// Module pend_scoreboard_chk
// Property checks for pend_scoreboard, attached by bind.
// Assumes: set_q is the delayed set stage inside the vector module.
module pend_scoreboard_chk #(
    parameter int NREG = 32,
    parameter int NRD  = 3,
    parameter int NWR  = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NREG-1:0] set_m,
    input logic [NREG-1:0] clr_m,
    input logic [NREG-1:0] set_q,
    input logic [NREG-1:0] pend_q,
    input logic [NREG-1:0] pend_byp,
    input logic [NRD-1:0]  rd_vld,
    input logic [NRD-1:0]  rd_busy,
    input logic [NRD-1:0]  rd_hz,
    input logic [NWR-1:0]  wr_vld,
    input logic [NWR-1:0]  wr_busy,
    input logic [NWR-1:0]  wr_hz
);
    // R1
    reset_empty_chk: assert property (@(posedge clk)
        !rst_n |=> (pend_q == '0 && set_q == '0));

    // R2
    set_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_m != '0) |=> ((pend_byp & $past(set_m)) == $past(set_m)));

    // R3
    clear_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_m & ~set_q) != '0) |=> ((pend_q & $past(clr_m & ~set_q)) == '0));

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_q & clr_m) != '0) |=> ((pend_q & $past(set_q & clr_m)) == $past(set_q & clr_m)));

    // R6
    raw_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hz != '0) |-> (pend_q != '0 && (rd_hz & ~rd_vld) == '0));

    // R7
    waw_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hz != '0) |-> (pend_byp != '0 && (wr_hz & ~wr_vld) == '0));

    for (genvar i = 0; i < NRD; i++) begin : g_rd
        // R9
        rd_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_vld[i] && rd_busy[i] && !rd_hz[i]) |=> (!rd_vld[i] || !rd_hz[i]));
    end

    for (genvar i = 0; i < NWR; i++) begin : g_wr
        // R9
        wr_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_vld[i] && wr_busy[i] && !wr_hz[i]) |=> (!wr_vld[i] || !wr_hz[i]));
    end

endmodule

bind pend_scoreboard pend_scoreboard_chk #(
    .NREG (NREG),
    .NRD  (NRD),
    .NWR  (NWR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_m    (set_m),
    .clr_m    (clr_m),
    .set_q    (set_dly),
    .pend_q   (pend_q),
    .pend_byp (pend_byp),
    .rd_vld   (rd_vld),
    .rd_busy  (rd_busy),
    .rd_hz    (rd_hz),
    .wr_vld   (wr_vld),
    .wr_busy  (wr_busy),
    .wr_hz    (wr_hz)
);

// File: tb/pend_scoreboard_test.sv
`timescale 1ns/1ps
module pend_scoreboard_test;
    localparam int NREG = 32;
    localparam int NSET = 2;
    localparam int NCLR = 2;
    localparam int NRD  = 3;
    localparam int NWR  = 2;
    localparam int IW   = 5;

    logic                 clk;
    logic                 rst_n;
    logic [NSET-1:0]      set_vld, set_fmt;
    logic [NSET*NREG-1:0] set_mask;
    logic [NSET*IW-1:0]   set_num;
    logic [NCLR-1:0]      clr_vld, clr_fmt;
    logic [NCLR*NREG-1:0] clr_mask;
    logic [NCLR*IW-1:0]   clr_num;
    logic [NRD-1:0]       rd_vld, rd_fmt, rd_busy;
    logic [NRD*NREG-1:0]  rd_mask;
    logic [NRD*IW-1:0]    rd_num;
    logic [NWR-1:0]       wr_vld, wr_fmt, wr_busy;
    logic [NWR*NREG-1:0]  wr_mask;
    logic [NWR*IW-1:0]    wr_num;
    logic [NREG-1:0]      pend_q, pend_byp;
    logic [NRD-1:0]       rd_hz;
    logic [NWR-1:0]       wr_hz;
    logic                 raw_any, waw_any;

    pend_scoreboard #(.NREG(NREG), .NSET(NSET), .NCLR(NCLR), .NRD(NRD), .NWR(NWR)) uut (
        .clk(clk), .rst_n(rst_n),
        .set_vld(set_vld), .set_fmt(set_fmt), .set_mask(set_mask), .set_num(set_num),
        .clr_vld(clr_vld), .clr_fmt(clr_fmt), .clr_mask(clr_mask), .clr_num(clr_num),
        .rd_vld(rd_vld), .rd_fmt(rd_fmt), .rd_mask(rd_mask), .rd_num(rd_num), .rd_busy(rd_busy),
        .wr_vld(wr_vld), .wr_fmt(wr_fmt), .wr_mask(wr_mask), .wr_num(wr_num), .wr_busy(wr_busy),
        .pend_q(pend_q), .pend_byp(pend_byp), .rd_hz(rd_hz), .wr_hz(wr_hz),
        .raw_any(raw_any), .waw_any(waw_any)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural model state
    logic [NREG-1:0] m_vec, m_pipe;
    logic [NRD-1:0]  m_rset;
    logic [NWR-1:0]  m_wset;

    function automatic logic [NREG-1:0] dec(logic v, logic f, logic [NREG-1:0] m, logic [IW-1:0] n);
        if (!v) return '0;
        if (f) return NREG'(1) << n;
        return m;
    endfunction

    task automatic chk(string tag, string what, logic [NREG-1:0] act, logic [NREG-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic clear_inputs;
        set_vld = '0; set_fmt = '0; set_mask = '0; set_num = '0;
        clr_vld = '0; clr_fmt = '0; clr_mask = '0; clr_num = '0;
        rd_vld = '0; rd_fmt = '0; rd_mask = '0; rd_num = '0; rd_busy = '0;
        wr_vld = '0; wr_fmt = '0; wr_mask = '0; wr_num = '0; wr_busy = '0;
    endtask

    // grp: 0 set, 1 clear, 2 read check, 3 destination check
    task automatic req(int grp, int p, bit f, logic [NREG-1:0] val);
        case (grp)
            0: begin set_vld[p] = 1'b1; set_fmt[p] = f; set_mask[p*NREG +: NREG] = val; set_num[p*IW +: IW] = val[IW-1:0]; end
            1: begin clr_vld[p] = 1'b1; clr_fmt[p] = f; clr_mask[p*NREG +: NREG] = val; clr_num[p*IW +: IW] = val[IW-1:0]; end
            2: begin rd_vld[p]  = 1'b1; rd_fmt[p]  = f; rd_mask[p*NREG +: NREG]  = val; rd_num[p*IW +: IW]  = val[IW-1:0]; end
            default: begin wr_vld[p] = 1'b1; wr_fmt[p] = f; wr_mask[p*NREG +: NREG] = val; wr_num[p*IW +: IW] = val[IW-1:0]; end
        endcase
    endtask

    // compare every output with the model, then advance one clock
    task automatic step(string tag);
        logic [NREG-1:0] sm, cm, byp;
        logic [NRD-1:0]  erd;
        logic [NWR-1:0]  ewr;
        #0.5;
        sm = '0; cm = '0;
        for (int p = 0; p < NSET; p++) sm |= dec(set_vld[p], set_fmt[p], set_mask[p*NREG +: NREG], set_num[p*IW +: IW]);
        for (int p = 0; p < NCLR; p++) cm |= dec(clr_vld[p], clr_fmt[p], clr_mask[p*NREG +: NREG], clr_num[p*IW +: IW]);
        byp = (m_vec & ~cm) | m_pipe;
        for (int i = 0; i < NRD; i++)
            erd[i] = rd_vld[i] && !m_rset[i] && ((m_vec & dec(rd_vld[i], rd_fmt[i], rd_mask[i*NREG +: NREG], rd_num[i*IW +: IW])) != '0);
        for (int i = 0; i < NWR; i++)
            ewr[i] = wr_vld[i] && !m_wset[i] && ((byp & dec(wr_vld[i], wr_fmt[i], wr_mask[i*NREG +: NREG], wr_num[i*IW +: IW])) != '0);
        chk(tag, "pend_q", pend_q, m_vec);
        chk(tag, "pend_byp", pend_byp, byp);
        chk(tag, "rd_hz", NREG'(rd_hz), NREG'(erd));
        chk(tag, "wr_hz", NREG'(wr_hz), NREG'(ewr));
        chk(tag, "raw_any", NREG'(raw_any), NREG'(|erd));
        chk(tag, "waw_any", NREG'(waw_any), NREG'(|ewr));
        @(posedge clk);
        if (!rst_n) begin
            m_vec = '0; m_pipe = '0; m_rset = '0; m_wset = '0;
        end else begin
            m_vec = byp;
            m_pipe = sm;
            for (int i = 0; i < NRD; i++) m_rset[i] = rd_vld[i] && (m_rset[i] || (rd_busy[i] && !erd[i]));
            for (int i = 0; i < NWR; i++) m_wset[i] = wr_vld[i] && (m_wset[i] || (wr_busy[i] && !ewr[i]));
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        clear_inputs();
        rst_n = 1'b0;
        m_vec = '0; m_pipe = '0; m_rset = '0; m_wset = '0;
        @(negedge clk); @(negedge clk);
        // R1: reset state
        step("R1");
        chk("R1", "pend_q after reset", pend_q, '0);
        rst_n = 1'b1;
        step("R1");

        // R2: two ports merged, byp one cycle later, q two cycles later
        req(0, 0, 1'b0, 32'h8); req(0, 1, 1'b1, 32'd7);
        #0.2 chk("R2", "byp in request cycle", pend_byp, '0);
        step("R2"); clear_inputs();
        #0.2 chk("R2", "byp one cycle later", pend_byp, 32'h88);
        chk("R2", "q one cycle later", pend_q, '0);
        step("R2");
        chk("R2", "q two cycles later", pend_q, 32'h88);

        // R5: invalid mask request ignored, number 31 decoded
        set_mask[NREG-1:0] = '1; set_fmt[0] = 1'b0;
        req(0, 1, 1'b1, 32'd31);
        step("R5"); clear_inputs();
        step("R5");
        chk("R5", "formats and invalid request", pend_q, 32'h8000_0088);

        // R3: clears by number and by mask, both ports
        req(1, 0, 1'b1, 32'd3); req(1, 1, 1'b0, 32'h80);
        #0.2 chk("R3", "byp clears same cycle", pend_byp, 32'h8000_0000);
        step("R3"); clear_inputs();
        chk("R3", "q cleared", pend_q, 32'h8000_0000);

        // R4: clear meets delayed set on register 5
        req(0, 0, 1'b1, 32'd5);
        step("R4"); clear_inputs();
        req(1, 0, 1'b1, 32'd5); req(1, 1, 1'b0, 32'h20);
        step("R4"); clear_inputs();
        chk("R4", "set beats clear", pend_q, 32'h8000_0020);
        req(1, 0, 1'b1, 32'd5);
        step("R4"); clear_inputs();
        chk("R4", "later clear works", pend_q, 32'h8000_0000);

        // R6: read checks against pending 31 and empty 2
        req(2, 0, 1'b1, 32'd31); req(2, 1, 1'b0, 32'h4);
        #0.2 chk("R6", "rd_hz", NREG'(rd_hz), 32'h1);
        chk("R10", "raw_any", NREG'(raw_any), 32'h1);
        step("R6"); clear_inputs();
        step("R6");

        // R8: read and write of register 10 in its own issue cycle
        req(0, 0, 1'b1, 32'd10);
        req(2, 0, 1'b1, 32'd10); rd_busy[0] = 1'b1;
        req(3, 0, 1'b1, 32'd10); wr_busy[0] = 1'b1;
        #0.2 chk("R8", "no self read hazard", NREG'(rd_hz), '0);
        chk("R8", "no self write hazard", NREG'(wr_hz), '0);
        step("R8");
        set_vld = '0;
        // R9: settled checks stay quiet, a fresh one still holds
        #0.2 chk("R9", "settled destination", NREG'(wr_hz), '0);
        chk("R9", "settled read", NREG'(rd_hz), '0);
        step("R9");
        req(2, 1, 1'b1, 32'd10);
        #0.2 chk("R9", "other read holds", NREG'(rd_hz), 32'h2);
        step("R9"); clear_inputs();
        step("R9");

        // R7: destination sees set via bypass before read sees it
        req(0, 1, 1'b0, 32'h1000);
        step("R7"); clear_inputs();
        req(3, 1, 1'b1, 32'd12); req(2, 2, 1'b1, 32'd12);
        #0.2 chk("R7", "wr_hz via bypass", NREG'(wr_hz), 32'h2);
        chk("R7", "rd not yet", NREG'(rd_hz), '0);
        chk("R10", "waw_any", NREG'(waw_any), 32'h1);
        step("R7"); clear_inputs();
        step("R7");

        // R10: random traffic, with one mid-run reset
        for (int c = 0; c < 400; c++) begin
            set_vld = NSET'($urandom); set_fmt = NSET'($urandom);
            clr_vld = NCLR'($urandom); clr_fmt = NCLR'($urandom);
            for (int p = 0; p < NSET; p++) begin set_mask[p*NREG +: NREG] = NREG'(1) << ($urandom % NREG); set_num[p*IW +: IW] = IW'($urandom); end
            for (int p = 0; p < NCLR; p++) begin clr_mask[p*NREG +: NREG] = NREG'($urandom); clr_num[p*IW +: IW] = IW'($urandom); end
            if (c % 3 == 0) begin
                rd_vld = NRD'($urandom); rd_fmt = NRD'($urandom);
                wr_vld = NWR'($urandom); wr_fmt = NWR'($urandom);
                for (int p = 0; p < NRD; p++) begin rd_mask[p*NREG +: NREG] = NREG'($urandom); rd_num[p*IW +: IW] = IW'($urandom); end
                for (int p = 0; p < NWR; p++) begin wr_mask[p*NREG +: NREG] = NREG'($urandom); wr_num[p*IW +: IW] = IW'($urandom); end
            end
            rd_busy = NRD'($urandom); wr_busy = NWR'($urandom);
            rst_n = !(c == 200 || c == 201);
            step(rst_n ? "R10" : "R1");
        end
        rst_n = 1'b1;
        clear_inputs();
        step("R10");

        done = 1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule